// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides what a single-precision fused multiply-add `(a*b)+c` returns when a NaN is involved. It classifies each of the three operands as an ordinary number, a quiet NaN or a signaling NaN. A 3-bit policy input chooses one of several rule sets for the priority among the operands and for the case where one multiplicand is infinity and the other is zero. The caller detects that case and reports it on an input. The block drives a 2-bit choice, the final 32-bit value and an invalid-operation flag.

A chosen signaling operand is turned quiet before it leaves the block. The bit edit depends on the quiet-bit convention input. A default-NaN mode replaces the value with the canonical NaN for the active convention and leaves the choice and the flag as they are. All three outputs are registered, so each result appears one clock after its inputs.

Top module: `fma_nan_sel`

## Requirements
- R1: An operand is a NaN when bits [30:23] are all ones and bits [22:0] are not zero. With `qbit_inv`=0 a NaN is signaling when bit 22 is 0. With `qbit_inv`=1 it is signaling when bit 22 is 1. Any other NaN is quiet.
- R2: `pick_q` encodes 0 = a, 1 = b, 2 = c and 3 = default NaN. All outputs update on the clock edge after their inputs. Reset clears `pick_q`, `nan_out` and `invalid` to zero.
- R3: Policy 0. If `inf_zero` is set and c is a quiet NaN, the choice is 3 and invalid is raised. Otherwise the first match wins in this order: signaling c, signaling a, signaling b, quiet c, quiet a, else b.
- R4: Policy 1. If `inf_zero` is set, the choice is 3 and invalid is raised. Otherwise the first match wins in this order: signaling a, b, c, then quiet a, quiet b, else c.
- R5: Policy 2. If `inf_zero` is set, the choice is c and invalid is raised. Otherwise it uses the same order as policy 0.
- R6: Policy 3. If `inf_zero` is set, the choice is c and invalid is raised. Otherwise it picks a if a is any NaN, else c if c is any NaN, else b.
- R7: Policy 4 always chooses 3. It raises invalid for `inf_zero` only when no signaling operand is present.
- R8: Policy 5. If `inf_zero` is set, the choice is c and invalid is raised. Otherwise, with `first_nan`=1 it picks the first NaN in the order a, b, c (fallback c). With `first_nan`=0 it uses the order c, b, a (fallback a).
- R9: Policies 6 and 7 pick the first NaN in the order a, b, c (fallback c). For these policies `inf_zero` neither changes the choice nor raises invalid.
- R10: `invalid` is 1 whenever any operand is a signaling NaN, under every policy.
- R11: A chosen signaling operand is made quiet before output. With `qbit_inv`=0, bit 22 is set. With `qbit_inv`=1, bit 22 is cleared and bit 21 is set. Any other chosen operand passes through unchanged.
- R12: The default NaN is 0x7FC00000 when `qbit_inv`=0 and 0x7FBFFFFF when `qbit_inv`=1. It is driven whenever the choice is 3.
- R13: With `dnan_en`=1 the value is always the default NaN. `pick_q` and `invalid` are the same as with `dnan_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_c | input | 32 | Addend |
| inf_zero | input | 1 | Caller flag: one multiplicand is infinity and the other is zero |
| policy | input | 3 | Rule set select |
| qbit_inv | input | 1 | Quiet-bit convention: 1 means a set fraction MSB marks a signaling NaN |
| first_nan | input | 1 | Ordering mode for policy 5 |
| dnan_en | input | 1 | Force the default NaN as the value |
| pick_q | output | 2 | Chosen source |
| nan_out | output | 32 | Final value |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default single-precision parameters: an 8-bit exponent, a 23-bit fraction and a 3-bit policy field. This makes every policy value reachable, including both catch-all codes 6 and 7. Operands are distinct NaN patterns whose low fraction bits tag their source, so a wrong choice shows up in the value as well as in `pick_q`. Both quiet-bit conventions are exercised, which brings within reach the two silencing edits, the two default patterns, and the policy-1 case that only makes sense under the inverted convention.

// File: rtl/fma_nan_pkg.sv
`timescale 1ns/1ps
package fma_nan_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int POL_W  = 3;
    localparam int SEL_W  = 2;
    localparam int NOPS   = 3;

    localparam logic [SEL_W-1:0] SEL_A   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_B   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_C   = 2'd2;
    localparam logic [SEL_W-1:0] SEL_DEF = 2'd3;

    localparam logic [POL_W-1:0] POL_CAB_DEFQ = 3'd0;
    localparam logic [POL_W-1:0] POL_ABC_DEF  = 3'd1;
    localparam logic [POL_W-1:0] POL_CAB_C    = 3'd2;
    localparam logic [POL_W-1:0] POL_ACB_C    = 3'd3;
    localparam logic [POL_W-1:0] POL_ALW_DEF  = 3'd4;
    localparam logic [POL_W-1:0] POL_MODE_C   = 3'd5;

    typedef struct packed {
        logic [SEL_W-1:0] pick;
        logic [FP_W-1:0]  value;
        logic             invalid;
    } sel_out_t;
endpackage

// File: rtl/fnan_classify.sv
`timescale 1ns/1ps
module fnan_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    input  logic                  qbit_inv,
    output logic                  is_nan,
    output logic                  is_snan
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones = &operand[FRAC_W +: EXP_W];
        frac_nz  = |operand[FRAC_W-1:0];
        is_nan   = exp_ones && frac_nz;
        is_snan  = is_nan && (operand[FRAC_W-1] == qbit_inv);
    end
endmodule

// File: rtl/fnan_priority.sv
`timescale 1ns/1ps
module fnan_priority
    import fma_nan_pkg::*;
#(
    parameter int N = 3
) (
    input  logic [POL_W-1:0] policy,
    input  logic             inf_zero,
    input  logic             first_nan,
    input  logic [N-1:0]     nan_v,
    input  logic [N-1:0]     snan_v,
    output logic [SEL_W-1:0] pick,
    output logic             iz_invalid
);
    logic na, nb, nc, sa, sb, sc, qa, qb, qc;

    always_comb begin
        na = nan_v[0];  nb = nan_v[1];  nc = nan_v[2];
        sa = snan_v[0]; sb = snan_v[1]; sc = snan_v[2];
        qa = na && !sa; qb = nb && !sb; qc = nc && !sc;
        pick       = SEL_C;
        iz_invalid = 1'b0;
        case (policy)
            POL_CAB_DEFQ, POL_CAB_C: begin
                if (inf_zero && (policy == POL_CAB_C || qc)) begin
                    pick       = (policy == POL_CAB_C) ? SEL_C : SEL_DEF;
                    iz_invalid = 1'b1;
                end else if (sc) pick = SEL_C;
                else if (sa)     pick = SEL_A;
                else if (sb)     pick = SEL_B;
                else if (qc)     pick = SEL_C;
                else if (qa)     pick = SEL_A;
                else             pick = SEL_B;
            end
            POL_ABC_DEF: begin
                if (inf_zero) begin
                    pick       = SEL_DEF;
                    iz_invalid = 1'b1;
                end else if (sa) pick = SEL_A;
                else if (sb)     pick = SEL_B;
                else if (sc)     pick = SEL_C;
                else if (qa)     pick = SEL_A;
                else if (qb)     pick = SEL_B;
                else             pick = SEL_C;
            end
            POL_ACB_C: begin
                if (inf_zero) begin
                    pick       = SEL_C;
                    iz_invalid = 1'b1;
                end else if (na) pick = SEL_A;
                else if (nc)     pick = SEL_C;
                else             pick = SEL_B;
            end
            POL_ALW_DEF: begin
                pick       = SEL_DEF;
                iz_invalid = inf_zero;
            end
            POL_MODE_C: begin
                if (inf_zero) begin
                    pick       = SEL_C;
                    iz_invalid = 1'b1;
                end else if (first_nan) begin
                    if (na)      pick = SEL_A;
                    else if (nb) pick = SEL_B;
                    else         pick = SEL_C;
                end else begin
                    if (nc)      pick = SEL_C;
                    else if (nb) pick = SEL_B;
                    else         pick = SEL_A;
                end
            end
            default: begin
                if (na)      pick = SEL_A;
                else if (nb) pick = SEL_B;
                else         pick = SEL_C;
            end
        endcase
    end
endmodule

// File: rtl/fnan_shape.sv
`timescale 1ns/1ps
module fnan_shape
    import fma_nan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] chosen,
    input  logic                  chosen_snan,
    input  logic                  qbit_inv,
    input  logic                  use_default,
    output logic [EXP_W+FRAC_W:0] value
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] DEF_STD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DEF_INV = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [W-1:0] quieted;

    always_comb begin
        quieted = chosen;
        if (chosen_snan) begin
            if (qbit_inv) begin
                quieted[FRAC_W-1] = 1'b0;
                quieted[FRAC_W-2] = 1'b1;
            end else begin
                quieted[FRAC_W-1] = 1'b1;
            end
        end
        if (use_default) value = qbit_inv ? DEF_INV : DEF_STD;
        else             value = quieted;
    end
endmodule

// File: rtl/fma_nan_sel.sv
`timescale 1ns/1ps
module fma_nan_sel
    import fma_nan_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int F_W = FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [E_W+F_W:0]   op_a,
    input  logic [E_W+F_W:0]   op_b,
    input  logic [E_W+F_W:0]   op_c,
    input  logic               inf_zero,
    input  logic [POL_W-1:0]   policy,
    input  logic               qbit_inv,
    input  logic               first_nan,
    input  logic               dnan_en,
    output logic [SEL_W-1:0]   pick_q,
    output logic [E_W+F_W:0]   nan_out,
    output logic               invalid
);
    localparam int W = 1 + E_W + F_W;

    logic [W-1:0]     ops [NOPS];
    logic [NOPS-1:0]  nan_v;
    logic [NOPS-1:0]  snan_v;
    logic [SEL_W-1:0] pick_c;
    logic             iz_inv;
    logic [W-1:0]     chosen;
    logic             chosen_snan;
    logic [W-1:0]     value_c;
    sel_out_t         out_d, out_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fnan_classify #(.EXP_W(E_W), .FRAC_W(F_W)) u_cls (
            .operand (ops[i]),
            .qbit_inv(qbit_inv),
            .is_nan  (nan_v[i]),
            .is_snan (snan_v[i])
        );
    end

    fnan_priority #(.N(NOPS)) u_pri (
        .policy    (policy),
        .inf_zero  (inf_zero),
        .first_nan (first_nan),
        .nan_v     (nan_v),
        .snan_v    (snan_v),
        .pick      (pick_c),
        .iz_invalid(iz_inv)
    );

    always_comb begin
        chosen      = ops[0];
        chosen_snan = snan_v[0];
        if (pick_c == SEL_B) begin
            chosen      = ops[1];
            chosen_snan = snan_v[1];
        end else if (pick_c == SEL_C) begin
            chosen      = ops[2];
            chosen_snan = snan_v[2];
        end
    end

    fnan_shape #(.EXP_W(E_W), .FRAC_W(F_W)) u_shape (
        .chosen     (chosen),
        .chosen_snan(chosen_snan),
        .qbit_inv   (qbit_inv),
        .use_default(dnan_en || (pick_c == SEL_DEF)),
        .value      (value_c)
    );

    always_comb begin
        out_d         = out_q;
        out_d.pick    = pick_c;
        out_d.value   = value_c;
        out_d.invalid = iz_inv || (|snan_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pick_q  = out_q.pick;
    assign nan_out = out_q.value;
    assign invalid = out_q.invalid;
endmodule

// File: rtl/fma_nan_sel_chk.sv
`timescale 1ns/1ps
module fma_nan_sel_chk #(
    parameter int E_W = 8,
    parameter int F_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic [E_W+F_W:0] op_a,
    input logic [E_W+F_W:0] op_b,
    input logic [E_W+F_W:0] op_c,
    input logic [2:0]       policy,
    input logic             qbit_inv,
    input logic             dnan_en,
    input logic [1:0]       pick_q,
    input logic [E_W+F_W:0] nan_out,
    input logic             invalid
);
    localparam int W = 1 + E_W + F_W;
    localparam logic [W-1:0] D0 = {1'b0, {E_W{1'b1}}, 1'b1, {(F_W-1){1'b0}}};
    localparam logic [W-1:0] D1 = {1'b0, {E_W{1'b1}}, 1'b0, {(F_W-1){1'b1}}};

    function automatic logic sig(input logic [W-1:0] v, input logic inv);
        return (&v[F_W +: E_W]) && (|v[F_W-1:0]) && (v[F_W-1] == inv);
    endfunction

    // R13: default-NaN mode forces the canonical pattern
    a_r13_dnan_value: assert property (@(posedge clk) disable iff (!rst_n)
        dnan_en |=> nan_out == ($past(qbit_inv) ? D1 : D0));

    // R7: policy 4 always selects the default NaN
    a_r7_always_default: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == 3'd4) |=> (pick_q == 2'd3));

    // R10: any signaling operand raises invalid
    a_r10_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (sig(op_a, qbit_inv) || sig(op_b, qbit_inv) || sig(op_c, qbit_inv)) |=> invalid);

    // R12: a default choice drives the convention's pattern
    a_r12_default_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_q == 2'd3) |-> nan_out == ($past(qbit_inv) ? D1 : D0));

    // R11: the output value is never a signaling NaN
    a_r11_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        !sig(nan_out, $past(qbit_inv)));
endmodule

bind fma_nan_sel fma_nan_sel_chk #(.E_W(E_W), .F_W(F_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .policy(policy), .qbit_inv(qbit_inv), .dnan_en(dnan_en),
    .pick_q(pick_q), .nan_out(nan_out), .invalid(invalid)
);

// File: tb/sim_fma_nan_sel.sv
`timescale 1ns/1ps
module sim_fma_nan_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        inf_zero = 1'b0;
    logic [2:0]  policy = '0;
    logic        qbit_inv = 1'b0, first_nan = 1'b0, dnan_en = 1'b0;
    logic [1:0]  pick_q;
    logic [31:0] nan_out;
    logic        invalid;
    int n_chk = 0, n_bad = 0;

    // Standard convention (bit 22 set = quiet)
    localparam logic [31:0] QA = 32'h7FC0000A, QB = 32'h7FC0000B, QC = 32'h7FC0000C;
    localparam logic [31:0] SA = 32'h7F80000A, SB = 32'h7F80000B, SC = 32'h7F80000C;
    localparam logic [31:0] NUM = 32'h3F800000;
    localparam logic [31:0] DEF0 = 32'h7FC00000, DEF1 = 32'h7FBFFFFF;

    always #5 clk = ~clk;

    fma_nan_sel u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .inf_zero(inf_zero), .policy(policy), .qbit_inv(qbit_inv),
        .first_nan(first_nan), .dnan_en(dnan_en),
        .pick_q(pick_q), .nan_out(nan_out), .invalid(invalid)
    );

    task automatic apply(input logic [31:0] a, b, c, input logic iz,
                         input logic [2:0] pol, input logic inv, fst, dn);
        op_a = a; op_b = b; op_c = c; inf_zero = iz; policy = pol;
        qbit_inv = inv; first_nan = fst; dnan_en = dn;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [1:0] ep,
                              input logic [31:0] ev, input logic ei);
        n_chk++;
        if (pick_q !== ep || nan_out !== ev || invalid !== ei) begin
            n_bad++;
            $display("FAIL %s: got pick=%0d val=%h inv=%b, expected pick=%0d val=%h inv=%b",
                     req, pick_q, nan_out, invalid, ep, ev, ei);
        end
    endtask

    task automatic t_reset;
        #1;
        expect_out("R2 reset", 2'd0, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic t_policy0;
        apply(SA, SB, SC, 0, 3'd0, 0, 0, 0); expect_out("R3 R11 snan c first", 2'd2, 32'h7FC0000C, 1);
        apply(QA, SB, QC, 0, 3'd0, 0, 0, 0); expect_out("R3 R10 snan b over qnan c", 2'd1, 32'h7FC0000B, 1);
        apply(QA, QB, NUM, 0, 3'd0, 0, 0, 0); expect_out("R3 qnan a", 2'd0, QA, 0);
        apply(NUM, NUM, QC, 1, 3'd0, 0, 0, 0); expect_out("R3 R12 infzero qnan c", 2'd3, DEF0, 1);
        apply(QA, NUM, NUM, 1, 3'd0, 0, 0, 0); expect_out("R3 infzero without qnan c", 2'd0, QA, 0);
    endtask

    task automatic t_policy1;
        // inverted convention: bit 22 set = signaling
        apply(SA, QB, QC, 0, 3'd1, 1, 0, 0); expect_out("R1 R4 R11 inverted snan b", 2'd1, 32'h7FA0000B, 1);
        apply(NUM, SB, SC, 0, 3'd1, 1, 0, 0); expect_out("R4 quiet b", 2'd1, SB, 0);
        apply(NUM, NUM, SC, 1, 3'd1, 1, 0, 0); expect_out("R4 R12 infzero default", 2'd3, DEF1, 1);
    endtask

    task automatic t_policy2;
        apply(NUM, NUM, NUM, 1, 3'd2, 0, 0, 0); expect_out("R5 infzero returns c", 2'd2, NUM, 1);
        apply(SA, NUM, QC, 0, 3'd2, 0, 0, 0); expect_out("R5 snan a over qnan c", 2'd0, 32'h7FC0000A, 1);
    endtask

    task automatic t_policy3;
        apply(NUM, SB, QC, 0, 3'd3, 0, 0, 0); expect_out("R6 R10 c before b", 2'd2, QC, 1);
        apply(QA, NUM, SC, 0, 3'd3, 0, 0, 0); expect_out("R6 a first", 2'd0, QA, 1);
    endtask

    task automatic t_policy4;
        apply(QA, NUM, NUM, 0, 3'd4, 0, 0, 0); expect_out("R7 default no iz", 2'd3, DEF0, 0);
        apply(QA, NUM, NUM, 1, 3'd4, 0, 0, 0); expect_out("R7 default with iz", 2'd3, DEF0, 1);
    endtask

    task automatic t_policy5;
        apply(NUM, QB, QC, 0, 3'd5, 0, 1, 0); expect_out("R8 first mode b", 2'd1, QB, 0);
        apply(NUM, QB, QC, 0, 3'd5, 0, 0, 0); expect_out("R8 last mode c", 2'd2, QC, 0);
        apply(QA, NUM, NUM, 0, 3'd5, 0, 0, 0); expect_out("R8 last mode a", 2'd0, QA, 0);
        apply(QA, NUM, NUM, 1, 3'd5, 0, 1, 0); expect_out("R8 infzero c", 2'd2, NUM, 1);
    endtask

    task automatic t_other;
        apply(NUM, QB, NUM, 1, 3'd6, 0, 0, 0); expect_out("R9 policy 6 iz ignored", 2'd1, QB, 0);
        apply(QA, QB, QC, 1, 3'd7, 0, 0, 0); expect_out("R9 policy 7 a", 2'd0, QA, 0);
    endtask

    task automatic t_dnan;
        apply(SA, NUM, NUM, 0, 3'd2, 0, 0, 1); expect_out("R13 dn mode standard", 2'd0, DEF0, 1);
        apply(NUM, QB, NUM, 0, 3'd6, 1, 0, 1); expect_out("R13 dn mode inverted", 2'd1, DEF1, 1);
    endtask

    initial begin
        t_reset();
        t_policy0();
        t_policy1();
        t_policy2();
        t_policy3();
        t_policy4();
        t_policy5();
        t_other();
        t_dnan();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule